// File: doc/BRIEF.md
# Flash Synchronous Burst Read Sequencer

This block is the device-side engine of a multiplexed-bus flash memory for synchronous burst reads. On one clock in which the chip is selected, the address-valid strobe is low and the output enable is high, it captures a start address. It then holds its ready output low for a configurable number of wait states. After that it presents one 16-bit word per clock, taken from an attached array, while an internal pointer steps through the addresses.

The burst runs either without end, stepping linearly across any boundary, or wraps inside an aligned block of 8, 16 or 32 words. The output enable only gates the data drivers. A burst stops only when the chip is deselected or when a new address strobe starts a fresh burst. When the mode input selects asynchronous operation, the sequencer ignores address strobes entirely.

The array is outside the block. The sequencer presents a word address and expects the word back combinationally in the same cycle.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset the sequencer is idle: `rdy` is 1 and `dq_oe` is 0.
- R2: A burst starts only when, at a rising clock edge, `ce_n`=0, `avd_n`=0, `oe_n`=1 and `cfg_async`=0. That edge captures `addr_in`. A strobe with `oe_n`=0, or with `cfg_async`=1, is ignored: `rdy` stays 1 and `dq_oe` stays 0.
- R3: Call the capturing edge E0 and let `cfg_wait` hold W, from 0 to 15. `rdy` is 0 after edges E0 through E0+W. After edge E0+W+1, `rdy` is 1 and `dq_out` holds the word at the start address.
- R4: After each later edge, `dq_out` holds the word at the next address of the burst sequence, one word per clock.
- R5: `cfg_len`=0 gives a continuous burst. Each address is the previous one plus 1, and the carry propagates into all upper bits.
- R6: `cfg_len` values 1, 2 and 3 give linear bursts of 8, 16 and 32 words. Only the low 3, 4 or 5 address bits increment, wrapping modulo the block size, and the upper bits stay fixed. `cfg_len` is sampled at the starting edge.
- R7: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0 and the sequencer is in its data phase.
- R8: Raising `oe_n` during the data phase drops `dq_oe` but does not pause the burst. The address keeps advancing each clock, so after `oe_n` returns low the word shown is the one for the elapsed cycle count.
- R9: `ce_n`=1 at an edge ends the burst. The sequencer is then idle (`rdy`=1, `dq_oe`=0) and stays idle after `ce_n` returns low, until a new start.
- R10: A valid start during a burst abandons it. The new address is captured and a fresh latency of W wait states follows, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr_in | input | ADDR_W | Start word address |
| cfg_async | input | 1 | 1 = asynchronous mode, burst engine disabled |
| cfg_wait | input | WAIT_W | Initial wait-state count |
| cfg_len | input | 2 | Burst type: 0 continuous, 1/2/3 = 8/16/32-word wrap |
| arr_addr | output | ADDR_W | Word address presented to the array |
| arr_data | input | DATA_W | Array word at `arr_addr` |
| dq_out | output | DATA_W | Burst output data |
| dq_oe | output | 1 | Data output drive enable |
| rdy | output | 1 | Low during initial latency |

## Verification
The bench drives bursts with several wait counts, including zero. A continuous burst starts just below a 4K boundary, which shows that the carry reaches the upper bits. The three wrapping lengths start at unaligned offsets and run past the block end, which separates a wrap from a plain increment and separates each block size from the others. Mid-burst patterns cover an output-enable gap, deselection with reselection, and a restart at a new address. Each of these shows whether the pointer kept running, stopped, or reloaded. Strobes made with the output enable low or in asynchronous mode must leave the sequencer idle.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } fbs_state_e;

  typedef enum logic [1:0] {
    LEN_CONT = 2'd0,
    LEN_8    = 2'd1,
    LEN_16   = 2'd2,
    LEN_32   = 2'd3
  } fbs_len_e;
endpackage

// File: rtl/fbs_latency_timer.sv
module fbs_latency_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic              run,
  output logic              done
);
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) cnt_d = wait_in;
    else if (run && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

  // R3: the wait count is taken on load and then steps down by one
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(wait_in)));
  p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen
  import fbs_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              advance,
  input  fbs_len_e          len,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d, inc, step_mask;

  // Bits allowed to change on a step: all of them for a continuous burst,
  // otherwise only those below the wrap block size.
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    if (i < 3) begin : g_lo
      assign step_mask[i] = 1'b1;
    end else if (i == 3) begin : g_b3
      assign step_mask[i] = (len == LEN_CONT) || (len == LEN_16) || (len == LEN_32);
    end else if (i == 4) begin : g_b4
      assign step_mask[i] = (len == LEN_CONT) || (len == LEN_32);
    end else begin : g_hi
      assign step_mask[i] = (len == LEN_CONT);
    end
  end

  assign inc = ptr_q + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    if (load)         ptr_d = load_addr;
    else if (advance) ptr_d = (ptr_q & ~step_mask) | (inc & step_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5: continuous bursts carry into every bit
  p_cont_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && len == LEN_CONT) |=> (ptr_q == $past(ptr_q) + 1'b1));
  // R6: an 8-word burst never leaves its aligned block
  p_wrap8_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && len == LEN_8) |=>
      (ptr_q[ADDR_W-1:3] == $past(ptr_q[ADDR_W-1:3])) &&
      (ptr_q[2:0] == $past(ptr_q[2:0]) + 3'd1));
  // R6: a 32-word burst keeps the bits above bit 4
  p_wrap32_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && len == LEN_32) |=>
      (ptr_q[ADDR_W-1:5] == $past(ptr_q[ADDR_W-1:5])));
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq
  import fbs_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              avd_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cfg_async,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [1:0]        cfg_len,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              rdy
);
  localparam int SYNC_STAGES = 2;

  // Reset asserts at once and releases on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[SYNC_STAGES-1];

  fbs_state_e        state_q, state_d;
  fbs_len_e          len_q, len_d;
  logic [DATA_W-1:0] dq_q;
  logic              start, lat_done, advance;

  assign start = !ce_n && !avd_n && oe_n && !cfg_async;

  always_comb begin
    state_d = state_q;
    if (ce_n)       state_d = ST_IDLE;
    else if (start) state_d = ST_LAT;
    else if (state_q == ST_LAT && lat_done) state_d = ST_DATA;
  end

  assign len_d   = start ? fbs_len_e'(cfg_len) : len_q;
  assign advance = !ce_n && !start &&
                   ((state_q == ST_LAT && lat_done) || state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      len_q   <= LEN_CONT;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     dq_q <= '0;
    else if (advance) dq_q <= arr_data;
  end

  fbs_latency_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (start),
    .wait_in (cfg_wait),
    .run     (state_q == ST_LAT),
    .done    (lat_done)
  );

  fbs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load      (start),
    .load_addr (addr_in),
    .advance   (advance),
    .len       (len_q),
    .ptr       (arr_addr)
  );

  assign dq_out = dq_q;
  assign dq_oe  = (state_q == ST_DATA) && !ce_n && !oe_n;
  assign rdy    = (state_q != ST_LAT);

  // R3: the edge that captures an address opens the latency window
  p_start_rdy_low_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    start |=> !rdy);
  // R9: deselection returns the engine to idle
  p_ce_ends_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ce_n |=> (rdy && !dq_oe && state_q == ST_IDLE));
  // R8: the data phase persists whatever oe_n does
  p_oe_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_DATA && !ce_n && avd_n) |=> (state_q == ST_DATA));
  // R4: every data-phase clock fetches a new word from a new address
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == ST_DATA && !ce_n && avd_n) |=> (arr_addr != $past(arr_addr)));
endmodule

// File: tb/test_flash_burst_seq.sv
module test_flash_burst_seq;
  localparam int AW = 22;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, avd_n, oe_n, cfg_async;
  logic [AW-1:0] addr_in, arr_addr;
  logic [3:0]    cfg_wait;
  logic [1:0]    cfg_len;
  logic [DW-1:0] arr_data, dq_out;
  logic          dq_oe, rdy;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], 10'h2A5};
  endfunction

  assign arr_data = word_of(arr_addr);

  flash_burst_seq i_flash_burst_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .avd_n(avd_n), .oe_n(oe_n),
    .addr_in(addr_in), .cfg_async(cfg_async), .cfg_wait(cfg_wait),
    .cfg_len(cfg_len), .arr_addr(arr_addr), .arr_data(arr_data),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] seq_addr(logic [AW-1:0] s, logic [1:0] len, int k);
    logic [AW-1:0] m;
    case (len)
      2'd1:    m = AW'(7);
      2'd2:    m = AW'(15);
      2'd3:    m = AW'(31);
      default: m = '1;
    endcase
    return (s & ~m) | ((s + AW'(k)) & m);
  endfunction

  // Start a burst and check the latency window (R2, R3); returns at the negedge
  // where word 0 is visible.
  task automatic start_burst(input logic [AW-1:0] a, input logic [3:0] w, input logic [1:0] len);
    @(negedge clk);
    ce_n = 1'b0; avd_n = 1'b0; oe_n = 1'b1; addr_in = a;
    cfg_wait = w; cfg_len = len; cfg_async = 1'b0;
    @(negedge clk);
    avd_n = 1'b1; oe_n = 1'b0;
    check("R3 rdy low after capture", rdy, 0);
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      check("R3 rdy low in latency", rdy, 0);
    end
    @(negedge clk);
    check("R3 rdy high with first word", rdy, 1);
    check("R3 first word", dq_out, word_of(a));
  endtask

  task automatic follow(input string req, input logic [AW-1:0] a, input logic [1:0] len,
                        input int from, input int upto);
    for (int k = from; k < upto; k++) begin
      @(negedge clk);
      check(req, dq_out, word_of(seq_addr(a, len, k)));
      check("R7 drive enabled", dq_oe, 1);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; avd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 rdy after reset", rdy, 1);
    check("R1 dq_oe after reset", dq_oe, 0);
  endtask

  task automatic t_continuous();
    start_burst(22'h00FFE, 4'd3, 2'd0);
    follow("R5 continuous carry", 22'h00FFE, 2'd0, 1, 6);
    go_idle();
  endtask

  task automatic t_linear(input logic [AW-1:0] a, input logic [3:0] w,
                          input logic [1:0] len, input int n);
    start_burst(a, w, len);
    // R4 and R6: the run goes past the block end
    follow("R6 linear wrap", a, len, 1, n);
    go_idle();
  endtask

  task automatic t_oe_gap();
    logic [AW-1:0] a = 22'h01230;
    start_burst(a, 4'd1, 2'd0);
    follow("R4 word stream", a, 2'd0, 1, 2);
    oe_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 outputs off with oe_n high", dq_oe, 0);
      check("R8 no wait inserted", rdy, 1);
    end
    oe_n = 1'b0;
    @(negedge clk);
    check("R8 burst kept advancing", dq_out, word_of(a + 22'd5));
    check("R7 drive back on", dq_oe, 1);
    go_idle();
  endtask

  task automatic t_ce_end();
    start_burst(22'h00400, 4'd0, 2'd0);
    follow("R4 word stream", 22'h00400, 2'd0, 1, 3);
    ce_n = 1'b1;
    @(negedge clk);
    check("R9 rdy after deselect", rdy, 1);
    check("R9 dq_oe after deselect", dq_oe, 0);
    ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 stays idle after reselect", dq_oe, 0);
    end
    go_idle();
  endtask

  task automatic t_restart();
    start_burst(22'h00800, 4'd0, 2'd0);
    follow("R4 word stream", 22'h00800, 2'd0, 1, 3);
    // R10: new strobe in the middle of the burst
    start_burst(22'h15555, 4'd2, 2'd1);
    follow("R10 restarted burst", 22'h15555, 2'd1, 1, 9);
    go_idle();
  endtask

  task automatic t_ignored(input logic async_mode, input logic oe_level, input string req);
    @(negedge clk);
    ce_n = 1'b0; avd_n = 1'b0; oe_n = oe_level; cfg_async = async_mode;
    addr_in = 22'h00100; cfg_wait = 4'd0;
    @(negedge clk);
    avd_n = 1'b1; oe_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(req, {30'd0, rdy, dq_oe}, 32'd2);
      @(negedge clk);
    end
    cfg_async = 1'b0;
    go_idle();
  endtask

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; avd_n = 1'b1; oe_n = 1'b1;
    addr_in = '0; cfg_async = 1'b0; cfg_wait = '0; cfg_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_continuous();
    t_linear(22'h01235, 4'd2, 2'd1, 10);
    t_linear(22'h03ABC, 4'd0, 2'd2, 20);
    t_linear(22'h2001E, 4'd5, 2'd3, 34);
    t_linear(22'h00007, 4'd15, 2'd1, 3);
    t_oe_gap();
    t_ce_end();
    t_restart();
    t_ignored(1'b1, 1'b1, "R2 async mode ignores strobe");
    t_ignored(1'b0, 1'b0, "R2 strobe with oe_n low ignored");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule